// File: doc/BRIEF.md
# Memory Dependence Tracking Unit

This block sits beside the issue queue of an out-of-order core and decides when each in-flight load or store may be handed to the ready queue. Operations are identified by sequence numbers. A larger number means a younger operation, and the value zero is reserved to mean "no producer". Each operation enters a small table when it is inserted. At insertion it either depends on a producer (an active barrier, or a store named by an external predictor) or is memory-ready at once. Memory barriers also occupy table entries. They hold off later loads and/or stores until they complete.

One command is presented per cycle on a single command port with a valid/ready pair. Ready sequence numbers leave through a valid/ready output, one per cycle, lowest number first. The unit also supports three more actions. A squash removes the younger operations of one thread. A reschedule parks an operation on a replay list. A replay releases the whole list.

Top module: `memdep_tracker`

## Requirements
- R1: After reset the output is idle, no entry or barrier is held, and an insert is accepted (`cmd_ready` high).
- R2: `cmd_op` encodes 1 insert load, 2 insert store, 3 insert full barrier, 4 insert write barrier, 5 registers ready, 6 complete, 7 reschedule, 8 replay, 9 squash (0 idle). An inserted operation with producer 0 and `cmd_regs_rdy` high is presented on `out_seq` in the cycle after the accepting edge.
- R3: An operation without a producer whose registers are not ready waits until a registers-ready command for it. A nonzero producer number not present in the table counts as no dependency.
- R4: An operation whose producer is present is never presented before that producer completes. If its registers were ready, it is presented right after the completion.
- R5: A dependent whose registers are not ready when its producer completes is marked memory-ready only, and is presented after its registers-ready command.
- R6: While a full barrier is pending, new loads and stores depend on it whatever the predictor says. While only a write barrier is pending, new stores depend on it and loads take the predictor's producer.
- R7: Completing a barrier clears a barrier flag only if the flag still holds that barrier's number. A younger barrier keeps the flag set.
- R8: A squash with number N and thread T removes every entry of thread T numbered above N, including rescheduled ones. Removed entries are never presented, not even when their producer completes. Other threads are untouched.
- R9: A replay presents every rescheduled operation, oldest first, and empties the list, so that a second replay presents nothing.
- R10: When several operations are ready, they are presented one per cycle, lowest number first. `out_seq` holds while `out_ready` is low.
- R11: With all entries in use, `cmd_ready` is low for insert commands and stays high for all other commands.
- R12: Each producer accepts at most MAX_DEPS (default 4) dependents. An insert that would add one more sees `cmd_ready` low until the producer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 4 | Command code (see R2) |
| cmd_seq | input | SEQ_W | Sequence number the command refers to |
| cmd_tid | input | TID_W | Thread of the command |
| cmd_regs_rdy | input | 1 | On insert: register operands already ready |
| pred_seq | input | SEQ_W | Producer number from the dependence predictor (0 = none) |
| out_valid | output | 1 | A ready operation is presented |
| out_seq | output | SEQ_W | Its sequence number |
| out_ready | input | 1 | Consumer takes the presented operation |

## Verification
Every command takes effect on the rising edge that accepts it, and the output is decoded straight from table state. A newly ready operation therefore shows on `out_seq` one edge after its command, and the next candidate shows one edge after a handshake. `cmd_ready` is combinational and depends on the presented opcode and the table contents in the same cycle. The bench drives commands on the falling edge and samples `cmd_ready` shortly after it drives. It reads `out_valid`/`out_seq` on the falling edge that follows the accepting rising edge. Each presented number is consumed with a one-cycle `out_ready` pulse, so emission order and hold behaviour are observed cycle by cycle.

// File: rtl/memdep_pkg.sv
// Shared command encoding for the memory dependence tracker.
package memdep_pkg;
    typedef enum logic [3:0] {
        OP_IDLE    = 4'd0,
        OP_INS_LD  = 4'd1,
        OP_INS_ST  = 4'd2,
        OP_INS_FB  = 4'd3,
        OP_INS_WB  = 4'd4,
        OP_REGS    = 4'd5,
        OP_DONE    = 4'd6,
        OP_RESCHED = 4'd7,
        OP_REPLAY  = 4'd8,
        OP_SQUASH  = 4'd9
    } mdu_op_e;
endpackage

// File: rtl/memdep_cam.sv
// Associative lookup: finds the lowest live slot whose key equals the probe.
// Assumes live keys are unique; a duplicate resolves to the lowest index.
module memdep_cam #(
    parameter int N = 8,
    parameter int W = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*W-1:0] keys_flat,
    input  logic [N-1:0]   live,
    input  logic [W-1:0]   probe,
    output logic           hit,
    output logic [IW-1:0]  idx
);
    // Priority scan from the highest slot down so the lowest match wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i] && keys_flat[i*W +: W] == probe) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/memdep_free_find.sv
// Returns the lowest unused table slot and whether any slot is free.
module memdep_free_find #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  used,
    output logic          any_free,
    output logic [IW-1:0] idx
);
    // Downward scan so the lowest free index is kept.
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                any_free = 1'b1;
                idx      = IW'(i);
            end
        end
    end
endmodule

// File: rtl/memdep_oldest_pick.sv
// Selects, among requesting slots, the one with the smallest key.
// Assumes sequence numbers do not wrap while entries are live.
module memdep_oldest_pick #(
    parameter int N = 8,
    parameter int W = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req,
    input  logic [N*W-1:0] keys_flat,
    output logic           found,
    output logic [IW-1:0]  idx
);
    logic [W-1:0] best;

    // Linear minimum search over the requesting slots.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || keys_flat[i*W +: W] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = keys_flat[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/memdep_barrier_regs.sv
// Holds the load-side and store-side barrier flags with the number of the
// barrier that last set each. A full barrier sets both, a write barrier only
// the store side. Completion clears a side only when the numbers match.
module memdep_barrier_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_full,
    input  logic         set_write,
    input  logic [W-1:0] set_seq,
    input  logic         done_en,
    input  logic [W-1:0] done_seq,
    output logic         ld_on,
    output logic [W-1:0] ld_seq,
    output logic         st_on,
    output logic [W-1:0] st_seq
);
    // Load-side flag: set by full barriers, cleared by the matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_on  <= 1'b0;
            ld_seq <= '0;
        end else if (set_full) begin
            ld_on  <= 1'b1;
            ld_seq <= set_seq;
        end else if (done_en && ld_seq == done_seq) begin
            ld_on  <= 1'b0;
        end
    end

    // Store-side flag: set by either barrier kind, cleared on matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_on  <= 1'b0;
            st_seq <= '0;
        end else if (set_full || set_write) begin
            st_on  <= 1'b1;
            st_seq <= set_seq;
        end else if (done_en && st_seq == done_seq) begin
            st_on  <= 1'b0;
        end
    end
endmodule

// File: rtl/memdep_tracker.sv
// Memory dependence tracker. Keeps a table of in-flight loads, stores and
// barriers. Each entry records register readiness, memory readiness, a
// back-pointer to the producer it waits on, the count of dependents linked
// to it, a replay-list bit and a pending-output bit. Ready entries leave
// lowest sequence number first through a valid/ready output.
// Assumes: one command per cycle, unique live sequence numbers, 0 unused as a
// real number, no wrap while entries are live.
module memdep_tracker #(
    parameter int ENTRIES  = 8,
    parameter int SEQ_W    = 8,
    parameter int TID_W    = 1,
    parameter int MAX_DEPS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [3:0]       cmd_op,
    input  logic [SEQ_W-1:0] cmd_seq,
    input  logic [TID_W-1:0] cmd_tid,
    input  logic             cmd_regs_rdy,
    input  logic [SEQ_W-1:0] pred_seq,
    output logic             out_valid,
    output logic [SEQ_W-1:0] out_seq,
    input  logic             out_ready
);
    import memdep_pkg::*;

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int DW = $clog2(MAX_DEPS + 1);

    // Per-entry state.
    logic [ENTRIES-1:0] valid_vec, regs_vec, mrdy_vec, wait_vec, rep_vec, pend_vec;
    logic [SEQ_W-1:0]   e_seq  [ENTRIES];
    logic [TID_W-1:0]   e_tid  [ENTRIES];
    logic [IW-1:0]      e_prod [ENTRIES];
    logic [DW-1:0]      e_ndep [ENTRIES];

    logic [ENTRIES*SEQ_W-1:0] seq_flat;
    logic [ENTRIES*TID_W-1:0] tid_flat;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign seq_flat[g*SEQ_W +: SEQ_W] = e_seq[g];
        assign tid_flat[g*TID_W +: TID_W] = e_tid[g];
    end

    mdu_op_e op;
    logic    is_ld, is_st, is_mem_ins, is_bar_ins, is_ins;
    logic    ld_on, st_on;
    logic [SEQ_W-1:0] ld_seq, st_seq, prod_seq;
    logic    p_hit, c_hit, any_free, has_dep, dep_full, fire;
    logic [IW-1:0] p_idx, c_idx, f_idx, o_idx;
    logic    out_fire;

    // Command decode.
    always_comb begin
        op         = mdu_op_e'(cmd_op);
        is_ld      = (op == OP_INS_LD);
        is_st      = (op == OP_INS_ST);
        is_mem_ins = is_ld || is_st;
        is_bar_ins = (op == OP_INS_FB) || (op == OP_INS_WB);
        is_ins     = is_mem_ins || is_bar_ins;
    end

    // Producer choice: active matching barrier overrides the predictor.
    always_comb begin
        if (is_ld && ld_on)      prod_seq = ld_seq;
        else if (is_st && st_on) prod_seq = st_seq;
        else                     prod_seq = pred_seq;
    end

    memdep_cam #(.N(ENTRIES), .W(SEQ_W)) u_prod_cam (
        .keys_flat(seq_flat), .live(valid_vec), .probe(prod_seq),
        .hit(p_hit), .idx(p_idx)
    );

    memdep_cam #(.N(ENTRIES), .W(SEQ_W)) u_cmd_cam (
        .keys_flat(seq_flat), .live(valid_vec), .probe(cmd_seq),
        .hit(c_hit), .idx(c_idx)
    );

    memdep_free_find #(.N(ENTRIES)) u_free (
        .used(valid_vec), .any_free(any_free), .idx(f_idx)
    );

    memdep_oldest_pick #(.N(ENTRIES), .W(SEQ_W)) u_pick (
        .req(valid_vec & pend_vec), .keys_flat(seq_flat),
        .found(out_valid), .idx(o_idx)
    );

    // Acceptance: inserts need a free slot and room in the producer's list.
    always_comb begin
        has_dep   = is_mem_ins && (prod_seq != '0) && p_hit;
        dep_full  = has_dep && (e_ndep[p_idx] == DW'(MAX_DEPS));
        cmd_ready = !(is_ins && (!any_free || dep_full));
        fire      = cmd_valid && cmd_ready;
        out_seq   = e_seq[o_idx];
        out_fire  = out_valid && out_ready;
    end

    memdep_barrier_regs #(.W(SEQ_W)) u_bar (
        .clk(clk), .rst_n(rst_n),
        .set_full(fire && op == OP_INS_FB),
        .set_write(fire && op == OP_INS_WB),
        .set_seq(cmd_seq),
        .done_en(fire && op == OP_DONE && c_hit),
        .done_seq(cmd_seq),
        .ld_on(ld_on), .ld_seq(ld_seq), .st_on(st_on), .st_seq(st_seq)
    );

    // Table update: output handshake first, then the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
            regs_vec  <= '0;
            mrdy_vec  <= '0;
            wait_vec  <= '0;
            rep_vec   <= '0;
            pend_vec  <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                e_seq[i]  <= '0;
                e_tid[i]  <= '0;
                e_prod[i] <= '0;
                e_ndep[i] <= '0;
            end
        end else begin
            if (out_fire) pend_vec[o_idx] <= 1'b0;
            if (fire) begin
                case (op)
                    OP_INS_LD, OP_INS_ST: begin
                        valid_vec[f_idx] <= 1'b1;
                        e_seq[f_idx]     <= cmd_seq;
                        e_tid[f_idx]     <= cmd_tid;
                        e_ndep[f_idx]    <= '0;
                        rep_vec[f_idx]   <= 1'b0;
                        regs_vec[f_idx]  <= cmd_regs_rdy;
                        if (has_dep) begin
                            wait_vec[f_idx] <= 1'b1;
                            e_prod[f_idx]   <= p_idx;
                            mrdy_vec[f_idx] <= 1'b0;
                            pend_vec[f_idx] <= 1'b0;
                            e_ndep[p_idx]   <= e_ndep[p_idx] + DW'(1);
                        end else begin
                            wait_vec[f_idx] <= 1'b0;
                            mrdy_vec[f_idx] <= 1'b1;
                            pend_vec[f_idx] <= cmd_regs_rdy;
                        end
                    end
                    OP_INS_FB, OP_INS_WB: begin
                        valid_vec[f_idx] <= 1'b1;
                        e_seq[f_idx]     <= cmd_seq;
                        e_tid[f_idx]     <= cmd_tid;
                        e_ndep[f_idx]    <= '0;
                        regs_vec[f_idx]  <= 1'b0;
                        mrdy_vec[f_idx]  <= 1'b0;
                        wait_vec[f_idx]  <= 1'b0;
                        rep_vec[f_idx]   <= 1'b0;
                        pend_vec[f_idx]  <= 1'b0;
                    end
                    OP_REGS: begin
                        if (c_hit) begin
                            regs_vec[c_idx] <= 1'b1;
                            if (mrdy_vec[c_idx]) pend_vec[c_idx] <= 1'b1;
                        end
                    end
                    OP_DONE: begin
                        if (c_hit) begin
                            valid_vec[c_idx] <= 1'b0;
                            pend_vec[c_idx]  <= 1'b0;
                            rep_vec[c_idx]   <= 1'b0;
                            wait_vec[c_idx]  <= 1'b0;
                            e_ndep[c_idx]    <= '0;
                            for (int i = 0; i < ENTRIES; i++) begin
                                if (valid_vec[i] && wait_vec[i] && e_prod[i] == c_idx) begin
                                    wait_vec[i] <= 1'b0;
                                    mrdy_vec[i] <= 1'b1;
                                    if (regs_vec[i]) pend_vec[i] <= 1'b1;
                                end
                            end
                        end
                    end
                    OP_RESCHED: begin
                        if (c_hit) rep_vec[c_idx] <= 1'b1;
                    end
                    OP_REPLAY: begin
                        for (int i = 0; i < ENTRIES; i++) begin
                            if (valid_vec[i] && rep_vec[i]) begin
                                pend_vec[i] <= 1'b1;
                                rep_vec[i]  <= 1'b0;
                            end
                        end
                    end
                    OP_SQUASH: begin
                        for (int i = 0; i < ENTRIES; i++) begin
                            if (valid_vec[i] && tid_flat[i*TID_W +: TID_W] == cmd_tid
                                && e_seq[i] > cmd_seq) begin
                                valid_vec[i] <= 1'b0;
                                pend_vec[i]  <= 1'b0;
                                rep_vec[i]   <= 1'b0;
                                wait_vec[i]  <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/memdep_tracker_chk.sv
// Property checker for memdep_tracker, attached by the bind below.
// Watches table vectors and ports; drives nothing.
module memdep_tracker_chk #(
    parameter int ENTRIES = 8,
    parameter int SEQ_W   = 8,
    parameter int TID_W   = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic                     cmd_ready,
    input logic [3:0]               cmd_op,
    input logic [SEQ_W-1:0]         cmd_seq,
    input logic [TID_W-1:0]         cmd_tid,
    input logic                     out_valid,
    input logic [SEQ_W-1:0]         out_seq,
    input logic [ENTRIES-1:0]       valid_vec,
    input logic [ENTRIES-1:0]       pend_vec,
    input logic [ENTRIES-1:0]       wait_vec,
    input logic [ENTRIES-1:0]       rep_vec,
    input logic [ENTRIES*SEQ_W-1:0] seq_flat,
    input logic [ENTRIES*TID_W-1:0] tid_flat
);
    logic             sq_q;
    logic [SEQ_W-1:0] sq_seq_q;
    logic [TID_W-1:0] sq_tid_q;
    logic             survivor, older_ready, ins_op;

    // Remember the last accepted squash for a next-cycle check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q     <= 1'b0;
            sq_seq_q <= '0;
            sq_tid_q <= '0;
        end else begin
            sq_q     <= cmd_valid && cmd_ready && cmd_op == 4'd9;
            sq_seq_q <= cmd_seq;
            sq_tid_q <= cmd_tid;
        end
    end

    // Scan the table for squash survivors and for older ready entries.
    always_comb begin
        survivor    = 1'b0;
        older_ready = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid_vec[i] && tid_flat[i*TID_W +: TID_W] == sq_tid_q
                && seq_flat[i*SEQ_W +: SEQ_W] > sq_seq_q)
                survivor = 1'b1;
            if (valid_vec[i] && pend_vec[i] && seq_flat[i*SEQ_W +: SEQ_W] < out_seq)
                older_ready = 1'b1;
        end
        ins_op = (cmd_op >= 4'd1) && (cmd_op <= 4'd4);
    end

    assert_waiter_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_vec & pend_vec) == '0);

    assert_replay_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 4'd8) |=> (rep_vec == '0));

    assert_full_refuses_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((&valid_vec) && ins_op) |-> !cmd_ready);

    assert_squash_removes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q |-> !survivor);

    assert_lowest_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !older_ready);
endmodule

bind memdep_tracker memdep_tracker_chk #(
    .ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .TID_W(TID_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_seq(cmd_seq), .cmd_tid(cmd_tid),
    .out_valid(out_valid), .out_seq(out_seq),
    .valid_vec(valid_vec), .pend_vec(pend_vec), .wait_vec(wait_vec),
    .rep_vec(rep_vec), .seq_flat(seq_flat), .tid_flat(tid_flat)
);

// File: tb/memdep_tracker_tb_top.sv
// Directed bench for memdep_tracker: one task per scenario, each checking
// its own results against values derived from the requirements.
module memdep_tracker_tb_top;
    localparam logic [3:0] OP_LD = 4'd1, OP_ST = 4'd2, OP_FB = 4'd3, OP_WB = 4'd4,
                           OP_RG = 4'd5, OP_DN = 4'd6, OP_RS = 4'd7, OP_RP = 4'd8,
                           OP_SQ = 4'd9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [3:0] cmd_op = 4'd0;
    logic [7:0] cmd_seq = 8'd0;
    logic [0:0] cmd_tid = 1'b0;
    logic       cmd_regs_rdy = 1'b0;
    logic [7:0] pred_seq = 8'd0;
    logic       out_valid;
    logic [7:0] out_seq;
    logic       out_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    memdep_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_seq(cmd_seq), .cmd_tid(cmd_tid),
        .cmd_regs_rdy(cmd_regs_rdy), .pred_seq(pred_seq),
        .out_valid(out_valid), .out_seq(out_seq), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one command for one rising edge; returns cmd_ready as seen.
    task automatic send(input logic [3:0] op, input int seq, input int tid,
                        input bit regs, input int pred, output bit rdy);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_seq = 8'(seq);
        cmd_tid = 1'(tid);
        cmd_regs_rdy = regs;
        pred_seq = 8'(pred);
        #1 rdy = cmd_ready;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 4'd0;
    endtask

    task automatic cmd(input logic [3:0] op, input int seq, input int tid,
                       input bit regs, input int pred);
        bit r;
        send(op, seq, tid, regs, pred, r);
    endtask

    task automatic expect_out(input int seq, input string req);
        chk(out_valid && out_seq == 8'(seq), req, out_valid ? int'(out_seq) : -1, seq);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic expect_none(input string req);
        chk(!out_valid, req, out_valid ? int'(out_seq) : -1, -1);
    endtask

    task automatic t_reset();
        do_reset();
        expect_none("R1 idle after reset");
        cmd_op = OP_LD;
        #1 chk(cmd_ready, "R1 insert accepted", cmd_ready, 1);
        cmd_op = 4'd0;
        cmd(OP_LD, 3, 0, 1, 0);
        expect_out(3, "R1 no barrier after reset");
    endtask

    task automatic t_basic();
        do_reset();
        cmd(OP_LD, 5, 0, 1, 0);
        expect_out(5, "R2 independent load");
        expect_none("R2 single emission");
        cmd(OP_ST, 6, 0, 0, 0);
        expect_none("R3 waits for registers");
        cmd(OP_RG, 6, 0, 0, 0);
        expect_out(6, "R3 after registers ready");
        cmd(OP_LD, 7, 0, 1, 3);
        expect_out(7, "R3 absent producer");
    endtask

    task automatic t_dep();
        do_reset();
        cmd(OP_ST, 10, 0, 1, 0);
        expect_out(10, "R4 producer store");
        cmd(OP_LD, 11, 0, 1, 10);
        cmd(OP_LD, 12, 0, 0, 10);
        expect_none("R4 dependents held");
        cmd(OP_DN, 10, 0, 0, 0);
        expect_out(11, "R4 woken on completion");
        expect_none("R5 regs not ready");
        cmd(OP_RG, 12, 0, 0, 0);
        expect_out(12, "R5 after registers ready");
    endtask

    task automatic t_barrier();
        do_reset();
        cmd(OP_FB, 20, 0, 0, 0);
        cmd(OP_LD, 21, 0, 1, 0);
        cmd(OP_ST, 22, 0, 1, 0);
        expect_none("R6 full barrier holds both");
        cmd(OP_DN, 20, 0, 0, 0);
        expect_out(21, "R6 load after full barrier");
        expect_out(22, "R6 store after full barrier");
        cmd(OP_WB, 30, 0, 0, 0);
        cmd(OP_LD, 31, 0, 1, 0);
        expect_out(31, "R6 load passes write barrier");
        cmd(OP_ST, 32, 0, 1, 0);
        expect_none("R6 store held by write barrier");
        cmd(OP_WB, 33, 0, 0, 0);
        cmd(OP_DN, 30, 0, 0, 0);
        expect_out(32, "R7 older barrier wakes its store");
        cmd(OP_ST, 34, 0, 1, 0);
        expect_none("R7 younger barrier keeps flag");
        cmd(OP_DN, 33, 0, 0, 0);
        expect_out(34, "R7 released by own barrier");
    endtask

    task automatic t_squash();
        do_reset();
        cmd(OP_ST, 40, 0, 1, 0);
        expect_out(40, "R8 producer");
        cmd(OP_LD, 41, 0, 1, 40);
        cmd(OP_LD, 42, 1, 1, 40);
        cmd(OP_LD, 43, 0, 0, 0);
        cmd(OP_SQ, 40, 0, 0, 0);
        cmd(OP_DN, 40, 0, 0, 0);
        expect_out(42, "R8 other thread kept");
        expect_none("R8 squashed dependent not woken");
        cmd(OP_RG, 43, 0, 0, 0);
        expect_none("R8 squashed entry gone");
    endtask

    task automatic t_replay();
        do_reset();
        for (int s = 50; s <= 52; s++) begin
            cmd(OP_LD, s, 0, 1, 0);
            expect_out(s, "R9 first issue");
        end
        cmd(OP_RS, 52, 0, 0, 0);
        cmd(OP_RS, 50, 0, 0, 0);
        expect_none("R9 held until replay");
        cmd(OP_RP, 0, 0, 0, 0);
        expect_out(50, "R9 oldest replayed first");
        expect_out(52, "R9 second replayed");
        expect_none("R9 list drained");
        cmd(OP_RP, 0, 0, 0, 0);
        expect_none("R9 second replay empty");
    endtask

    task automatic t_order();
        do_reset();
        cmd(OP_FB, 59, 0, 0, 0);
        cmd(OP_LD, 63, 0, 1, 0);
        cmd(OP_LD, 61, 0, 1, 0);
        cmd(OP_LD, 62, 0, 1, 0);
        cmd(OP_DN, 59, 0, 0, 0);
        chk(out_valid && out_seq == 8'd61, "R10 lowest first", int'(out_seq), 61);
        @(negedge clk);
        chk(out_valid && out_seq == 8'd61, "R10 held without ready", int'(out_seq), 61);
        expect_out(61, "R10 taken");
        expect_out(62, "R10 next");
        expect_out(63, "R10 last");
    endtask

    task automatic t_full();
        bit r;
        do_reset();
        for (int s = 70; s < 78; s++) begin
            send(OP_LD, s, 0, 0, 0, r);
            chk(r, "R11 fill accepted", r, 1);
        end
        send(OP_LD, 78, 0, 1, 0, r);
        chk(!r, "R11 insert refused when full", r, 0);
        expect_none("R11 refused insert has no effect");
        send(OP_RG, 70, 0, 0, 0, r);
        chk(r, "R11 non-insert accepted", r, 1);
        expect_out(70, "R11 registers command acted");
        cmd(OP_DN, 70, 0, 0, 0);
        send(OP_LD, 78, 0, 1, 0, r);
        chk(r, "R11 insert after free", r, 1);
        expect_out(78, "R11 freed slot used");
    endtask

    task automatic t_deplimit();
        bit r;
        do_reset();
        cmd(OP_ST, 80, 0, 0, 0);
        for (int s = 81; s <= 84; s++) begin
            send(OP_LD, s, 0, 1, 80, r);
            chk(r, "R12 within limit", r, 1);
        end
        send(OP_LD, 85, 0, 1, 80, r);
        chk(!r, "R12 fifth dependent stalls", r, 0);
        cmd(OP_DN, 80, 0, 0, 0);
        for (int s = 81; s <= 84; s++) expect_out(s, "R12 dependents woken");
        send(OP_LD, 85, 0, 1, 80, r);
        chk(r, "R12 accepted after completion", r, 1);
        expect_out(85, "R12 no producer left");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_dep();
        t_barrier();
        t_squash();
        t_replay();
        t_order();
        t_full();
        t_deplimit();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule